// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

This block watches sixteen interrupt lines taken from several general-purpose pin ports and turns edges on them into interrupt requests and event pulses. Each line n can be fed from pin n of any one port. A 4-bit selector field per line chooses that port. Every pin passes through a two-stage synchronizer. The chosen signal is then compared with its previous sample, and each line has its own enables for the rising and the falling direction.

Each qualifying edge goes two ways, and a separate mask bit gates each way. Through the interrupt mask it sets a sticky pending flag. Software clears that flag by writing a one to it, and the flag drives the line's request output while the mask stays set. Through the event mask it makes a single-cycle pulse on the event output, and that path keeps no state. Software configures the block over a plain 32-bit register port. Writes take effect at the clock edge and reads return data in the same cycle. The pin inputs and the two output vectors are level and pulse signals with no handshake, so no back-pressure applies: an event pulse that nothing samples in its cycle is lost.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every selector, trigger-enable, mask and pending bit reads 0, and both the request vector and the event vector are 0.
- R2: The word address map is as follows. Addresses 0 to 3 hold the selectors, with line n at address n/4, bits [4*(n%4)+3 : 4*(n%4)]. Address 4 holds the rising enables, 5 the falling enables, 6 the interrupt mask and 7 the event mask, one bit per line at bit n. Address 8 holds the pending flags. Bits above 15 of every register read 0.
- R3: Line n follows pin n of the port whose index is in its selector field (pin bit port*16+n of `port_pins`). Pins of other ports have no effect on that line.
- R4: A 0-to-1 change on the selected pin of a line with its rising enable set is a qualifying edge. It shows on the outputs at the third rising clock edge after the pin changes, and not before.
- R5: A 1-to-0 change qualifies only when the falling enable is set. With both enables set, either direction qualifies. With neither set, no direction qualifies.
- R6: A qualifying edge sets the pending flag only when the line's interrupt-mask bit is 1. The request output for a line is 1 exactly while its pending flag and its interrupt-mask bit are both 1.
- R7: A qualifying edge on a line whose event-mask bit is 1 makes that line's event output 1 for exactly one clock cycle. This does not depend on the interrupt mask, and it never sets a pending flag by itself.
- R8: Writing to address 8 clears each pending flag whose write-data bit is 1 and leaves the other flags unchanged.
- R9: When a qualifying edge and a clearing write reach the same pending flag in the same cycle, the flag stays set.
- R10: Changing a line's selector field never produces a qualifying edge on that line, even when the old and new source pins differ in level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | NPORTS*NLINES | Pin levels, port p pin n at bit p*NLINES+n |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| irq_o | output | NLINES | Per-line interrupt request |
| evt_o | output | NLINES | Per-line single-cycle event pulse |

## Verification
A wrong stored sample or a wrong selector copy shows up three clock edges after the pin moves. It appears as a missing pulse on `evt_o` or as an extra pulse, and the scoreboard treats any pulse it was not told to expect as a failure. A wrong pending flag shows on `irq_o` in the cycle after the edge or the write that corrupted it. A read of address 8 exposes it directly, even when the interrupt mask hides it from `irq_o`. A selector change that slips through as an edge therefore reaches the ports within three cycles, as an extra event pulse or as a pending bit that should not be there.

// File: rtl/extint_pkg.sv
package extint_pkg;
  // width of one source-port selector field
  localparam int SEL_W = 4;
  // selector fields packed into one register word
  localparam int LINES_PER_REG = 4;
  // control words placed after the selector words
  localparam int OFS_RISE = 0;
  localparam int OFS_FALL = 1;
  localparam int OFS_IMSK = 2;
  localparam int OFS_EMSK = 3;
  localparam int OFS_PEND = 4;
  localparam int NUM_CTRL = 5;
endpackage

// File: rtl/extint_regfile.sv
module extint_regfile
  import extint_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NLINES-1:0]       pend_i,
  output logic [NLINES*SEL_W-1:0] sel_o,
  output logic [NLINES-1:0]       rise_o,
  output logic [NLINES-1:0]       fall_o,
  output logic [NLINES-1:0]       imsk_o,
  output logic [NLINES-1:0]       emsk_o,
  output logic [NLINES-1:0]       clr_o
);
  localparam int NSELREG = NLINES / LINES_PER_REG;
  localparam int SREG_W  = LINES_PER_REG * SEL_W;
  localparam int USED_W  = (NLINES > SREG_W) ? NLINES : SREG_W;
  localparam logic [ADDR_W-1:0] ADR_RISE = ADDR_W'(NSELREG + OFS_RISE);
  localparam logic [ADDR_W-1:0] ADR_FALL = ADDR_W'(NSELREG + OFS_FALL);
  localparam logic [ADDR_W-1:0] ADR_IMSK = ADDR_W'(NSELREG + OFS_IMSK);
  localparam logic [ADDR_W-1:0] ADR_EMSK = ADDR_W'(NSELREG + OFS_EMSK);
  localparam logic [ADDR_W-1:0] ADR_PEND = ADDR_W'(NSELREG + OFS_PEND);

  logic                    wr;
  logic [NLINES*SEL_W-1:0] sel_q;
  logic [NLINES-1:0]       rise_q, fall_q, imsk_q, emsk_q;

  assign wr = bus_en & bus_we;

  // selector words: one flat vector, word k covers lines 4k..4k+3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr) begin
      for (int k = 0; k < NSELREG; k++) begin
        if (bus_addr == ADDR_W'(k)) sel_q[k*SREG_W +: SREG_W] <= bus_wdata[SREG_W-1:0];
      end
    end
  end

  // per-line trigger and mask words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      imsk_q <= '0;
      emsk_q <= '0;
    end else if (wr) begin
      if (bus_addr == ADR_RISE) rise_q <= bus_wdata[NLINES-1:0];
      if (bus_addr == ADR_FALL) fall_q <= bus_wdata[NLINES-1:0];
      if (bus_addr == ADR_IMSK) imsk_q <= bus_wdata[NLINES-1:0];
      if (bus_addr == ADR_EMSK) emsk_q <= bus_wdata[NLINES-1:0];
    end
  end

  // write-one-to-clear strobe for the pending flags
  assign clr_o = (wr && bus_addr == ADR_PEND) ? bus_wdata[NLINES-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NSELREG; k++) begin
      if (bus_addr == ADDR_W'(k)) bus_rdata = DATA_W'(sel_q[k*SREG_W +: SREG_W]);
    end
    case (bus_addr)
      ADR_RISE: bus_rdata = DATA_W'(rise_q);
      ADR_FALL: bus_rdata = DATA_W'(fall_q);
      ADR_IMSK: bus_rdata = DATA_W'(imsk_q);
      ADR_EMSK: bus_rdata = DATA_W'(emsk_q);
      ADR_PEND: bus_rdata = DATA_W'(pend_i);
      default:  ;
    endcase
  end

  generate
    if (USED_W < DATA_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:USED_W];
    end
  endgenerate

  assign sel_o  = sel_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign imsk_o = imsk_q;
  assign emsk_o = emsk_q;
endmodule

// File: rtl/extint_srcmux.sv
module extint_srcmux
  import extint_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int NLINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLINES-1:0] pins_i,
  input  logic [NLINES*SEL_W-1:0]  sel_i,
  output logic [NLINES-1:0]        line_o
);
  localparam int NPINS = NPORTS * NLINES;

  logic [NPINS-1:0] meta_q, sync_q;

  // two-stage synchronizer on every pin, ahead of the selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
    end
  end

  // line n picks pin n of the selected port; a port index past NPORTS gives 0
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic pick;
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (sel_i[n*SEL_W +: SEL_W] == SEL_W'(p)) pick = sync_q[p*NLINES + n];
      end
    end
    assign line_o[n] = pick;
  end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       line_i,
  input  logic [NLINES*SEL_W-1:0] sel_i,
  input  logic [NLINES-1:0]       rise_en_i,
  input  logic [NLINES-1:0]       fall_en_i,
  input  logic [NLINES-1:0]       imsk_i,
  input  logic [NLINES-1:0]       emsk_i,
  input  logic [NLINES-1:0]       clr_i,
  output logic [NLINES-1:0]       pend_o,
  output logic [NLINES-1:0]       evt_o
);
  logic [NLINES-1:0]       prev_q, pend_q, evt_q, hit, swap;
  logic [NLINES*SEL_W-1:0] sel_q;

  for (genvar n = 0; n < NLINES; n++) begin : g_ln
    logic up, dn;
    assign swap[n] = sel_i[n*SEL_W +: SEL_W] != sel_q[n*SEL_W +: SEL_W];
    assign up      = line_i[n] & ~prev_q[n];
    assign dn      = ~line_i[n] & prev_q[n];
    // a source switch only reloads the previous sample, it never counts
    assign hit[n]  = ~swap[n] & ((up & rise_en_i[n]) | (dn & fall_en_i[n]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sel_q  <= '0;
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= line_i;
      sel_q  <= sel_i;
      pend_q <= (hit & imsk_i) | (pend_q & ~clr_i);
      evt_q  <= hit & emsk_i;
    end
  end

  assign pend_o = pend_q;
  assign evt_o  = evt_q;

  // R6: a flag only rises on a line whose interrupt mask was set
  a_r6_pend_needs_imask: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(imsk_i)) == '0);

  // R8: a flag only drops through a clearing write
  a_r8_pend_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q)) & ~$past(clr_i)) == '0);

  // R9: an edge that meets a clear leaves the flag set
  a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit & imsk_i & clr_i) & ~pend_q) == '0);

  // R7: a pulse needs the event mask
  a_r7_evt_needs_emask: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(emsk_i)) == '0);

  // R10: no pulse in the cycle after a source switch
  a_r10_no_edge_on_reselect: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & $past(swap)) == '0);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter  int NPORTS = 6,
  parameter  int NLINES = 16,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = $clog2(NLINES / LINES_PER_REG + NUM_CTRL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLINES-1:0] port_pins,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NLINES-1:0]        irq_o,
  output logic [NLINES-1:0]        evt_o
);
  logic [NLINES*SEL_W-1:0] sel;
  logic [NLINES-1:0]       rise_en, fall_en, imsk, emsk, clr, pend, line;

  extint_regfile #(.NLINES(NLINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend), .sel_o(sel),
    .rise_o(rise_en), .fall_o(fall_en), .imsk_o(imsk), .emsk_o(emsk), .clr_o(clr)
  );

  extint_srcmux #(.NPORTS(NPORTS), .NLINES(NLINES)) u_mux (
    .clk(clk), .rst_n(rst_n), .pins_i(port_pins), .sel_i(sel), .line_o(line)
  );

  extint_detect #(.NLINES(NLINES)) u_det (
    .clk(clk), .rst_n(rst_n), .line_i(line), .sel_i(sel), .rise_en_i(rise_en),
    .fall_en_i(fall_en), .imsk_i(imsk), .emsk_i(emsk), .clr_i(clr),
    .pend_o(pend), .evt_o(evt_o)
  );

  // the mask gates the request, not the stored flag
  assign irq_o = pend & imsk;
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
  localparam int NP = 6;
  localparam int NL = 16;
  localparam logic [3:0] A_SEL0 = 4'd0, A_SEL1 = 4'd1, A_SEL3 = 4'd3, A_RISE = 4'd4,
                         A_FALL = 4'd5, A_IMSK = 4'd6, A_EMSK = 4'd7, A_PEND = 4'd8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*NL-1:0] pins = '0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NL-1:0]   irq_o, evt_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;

  extint_ctrl #(.NPORTS(NP), .NLINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .port_pins(pins), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every event pulse must match the next expected item
  always @(negedge clk) begin
    if (rst_n && evt_o != '0) begin
      logic [15:0] e;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected event act=%h exp=none", evt_o);
      end else begin
        e = exp_q.pop_front();
        if (e !== evt_o) begin
          fails++;
          $display("FAIL R7 event act=%h exp=%h", evt_o, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // driver: change one pin, push the pulse expected from it, let it settle
  task automatic pin_edge(input int port, input int ln, input logic v, input logic [15:0] ev);
    @(negedge clk);
    pins[port*NL + ln] = v;
    if (ev != '0) exp_q.push_back(ev);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_all();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 32'h0);
    end
    chk("R1 irq after reset", {16'h0, irq_o}, 32'h0);
    chk("R1 evt after reset", {16'h0, evt_o}, 32'h0);

    // R2 configuration and layout
    wr(A_SEL1, 32'hABCD_0030);   // line 5 -> port 3
    wr(A_RISE, 32'h0000_00E5);
    wr(A_FALL, 32'h0000_0086);
    wr(A_IMSK, 32'h0000_00A3);
    wr(A_EMSK, 32'h0000_0084);
    rd(A_SEL1, d); chk("R2 selector word 1, upper bits 0", d, 32'h0000_0030);
    rd(A_SEL0, d); chk("R2 selector word 0 untouched", d, 32'h0);
    rd(A_RISE, d); chk("R2 rising enables", d, 32'h0000_00E5);
    rd(A_FALL, d); chk("R2 falling enables", d, 32'h0000_0086);
    rd(A_IMSK, d); chk("R2 interrupt mask", d, 32'h0000_00A3);
    rd(A_EMSK, d); chk("R2 event mask", d, 32'h0000_0084);
    wr(A_SEL3, 32'h0000_F000);
    rd(A_SEL3, d); chk("R2 line 15 field at bits 15:12", d, 32'h0000_F000);
    wr(A_SEL3, 32'h0);

    // R4 rising edge latency on line 0
    @(negedge clk); pins[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 no request before third edge", {16'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R4 request at third edge", {16'h0, irq_o}, 32'h0000_0001);
    rd(A_PEND, d); chk("R4 pending line 0", d, 32'h0000_0001);

    // R5 falling-only line 1
    pin_edge(0, 1, 1'b1, 16'h0);
    rd(A_PEND, d); chk("R5 rise ignored on falling-only line", d, 32'h0000_0001);
    pin_edge(0, 1, 1'b0, 16'h0);
    rd(A_PEND, d); chk("R5 fall sets line 1", d, 32'h0000_0003);

    // R5/R7 line 2 both edges, event only
    pin_edge(0, 2, 1'b1, 16'h0004);
    pin_edge(0, 2, 1'b0, 16'h0004);
    rd(A_PEND, d); chk("R7 events leave pending alone", d, 32'h0000_0003);
    chk("R7 no request from event line", {16'h0, irq_o}, 32'h0000_0003);

    // R6 line 6 enabled but masked both ways
    pin_edge(0, 6, 1'b1, 16'h0);
    rd(A_PEND, d); chk("R6 masked line sets nothing", d, 32'h0000_0003);

    // R3 line 5 follows port 3 only
    pin_edge(2, 5, 1'b1, 16'h0);
    pin_edge(0, 5, 1'b1, 16'h0);
    rd(A_PEND, d); chk("R3 other ports ignored", d, 32'h0000_0003);
    pin_edge(3, 5, 1'b1, 16'h0);
    rd(A_PEND, d); chk("R3 selected port drives line 5", d, 32'h0000_0023);

    // R10 switching source of line 7 from a low pin to a high pin
    pin_edge(1, 7, 1'b1, 16'h0);
    wr(A_SEL1, 32'h0000_1030);
    repeat (6) @(negedge clk);
    rd(A_PEND, d); chk("R10 reselect makes no edge", d, 32'h0000_0023);
    pin_edge(1, 7, 1'b0, 16'h0080);
    rd(A_PEND, d); chk("R10 new source active", d, 32'h0000_00A3);

    // R6 request gated by mask, flag kept
    wr(A_IMSK, 32'h0000_0083);
    @(negedge clk);
    chk("R6 request follows mask", {16'h0, irq_o}, 32'h0000_0083);
    rd(A_PEND, d); chk("R6 flag kept while masked", d, 32'h0000_00A3);
    wr(A_IMSK, 32'h0000_00A3);

    // R8 write-one-to-clear
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R8 zero write keeps flags", d, 32'h0000_00A3);
    wr(A_PEND, 32'h0000_0022);
    rd(A_PEND, d); chk("R8 selected flags cleared", d, 32'h0000_0081);
    @(negedge clk);
    chk("R8 request after clear", {16'h0, irq_o}, 32'h0000_0081);

    // R9 edge and clear in the same cycle on line 0
    pin_edge(0, 0, 1'b0, 16'h0);
    @(negedge clk); pins[0] = 1'b1;
    repeat (2) @(posedge clk);
    wr(A_PEND, 32'h0000_0001);
    rd(A_PEND, d); chk("R9 set wins over clear", d, 32'h0000_0081);
    wr(A_PEND, 32'h0000_0001);
    rd(A_PEND, d); chk("R9 plain clear afterwards", d, 32'h0000_0080);

    repeat (4) @(negedge clk);
    chk("R7 all expected events seen", exp_q.size(), 32'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule